// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This unit sits beside a FIFO core. It holds two threshold offsets and turns a fill count into two early-warning flags. The low-water flag is measured up from the empty end and the high-water flag is measured down from the full end. Each offset can point anywhere in the storage, and the two are set independently.

The level on `prog_sel` during master reset fixes the loading method until the next master reset, and it also sets the default thresholds. In parallel mode, write-clock strobes take offset words from the data bus. In serial mode, they take one bit at a time from `ser_din`. Either way, the offsets can be read back in parallel on the read clock.

A partial reset restarts the loading and readback sequences. It leaves the offsets and the method as they were. The fill count arrives already synchronized, so the flags are a pure compare against it.

Top module: `afo_top`

## Requirements
- R1: While master reset is active, `prog_sel`=1 selects parallel loading with both offsets set to DEF_PAR (127), and `prog_sel`=0 selects serial loading with both offsets set to DEF_SER (1023). After release, `dout` reads 0.
- R2: In parallel mode, each `wclk` edge with `wr_en` and `prog_sel` both high copies `din[OW-1:0]` into one offset register. The first such strobe after any reset goes to the low-water offset, the next to the high-water offset, and the order then keeps alternating.
- R3: In serial mode, each `wclk` edge with `ser_en` and `prog_sel` both high stores `ser_din`. The first OW strobes fill the low-water offset from bit 0 upward, and the next OW strobes fill the high-water offset from bit 0 upward. Once all 2*OW bits are loaded, further strobes change nothing.
- R4: Parallel strobes have no effect in serial mode, and serial strobes have no effect in parallel mode.
- R5: On each `rclk` edge with `rd_en` and `prog_sel` both high, `dout` takes one offset, zero-extended. After any reset the low-water offset comes first, and the order then alternates. `dout` holds its value at all other `rclk` edges.
- R6: `almost_empty` is 1 exactly when `fill_cnt` <= the low-water offset. It follows `fill_cnt` in the same cycle.
- R7: `almost_full` is 1 exactly when `fill_cnt` >= DEPTH minus the high-water offset. It follows `fill_cnt` in the same cycle.
- R8: A partial reset keeps both offsets and the loading method. It sends both alternation toggles back to the low-water offset and restarts the serial bit sequence at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock for all offset loading |
| rclk | input | 1 | Read-side clock for readback |
| mrst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, asynchronous, active low |
| prog_sel | input | 1 | Qualifies offset strobes; its level picks the method during master reset |
| ser_en | input | 1 | Serial bit strobe |
| ser_din | input | 1 | Serial offset bit |
| wr_en | input | 1 | Parallel word strobe |
| din | input | DW | Parallel offset word (low OW bits used) |
| rd_en | input | 1 | Readback strobe |
| dout | output | DW | Readback word |
| fill_cnt | input | CW | Synchronized FIFO fill count, 0 to DEPTH |
| almost_empty | output | 1 | Low-water flag |
| almost_full | output | 1 | High-water flag |

## Verification
A wrong value in either alternation toggle shows up at the next readback: the word on `dout` one `rclk` edge later is the other offset. A stray serial bit index puts a value into the wrong register, and this shows at readback, or sooner in the flag thresholds, which follow `fill_cnt` with no delay. To catch off-by-one errors, the bench checks the flags at the exact threshold value and one step beside it.

// File: rtl/afo_pkg.sv
package afo_pkg;
  typedef enum logic {
    LOAD_SER = 1'b0,
    LOAD_PAR = 1'b1
  } load_mode_e;
endpackage

// File: rtl/afo_rst_sync.sv
module afo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/afo_wr_offsets.sv
module afo_wr_offsets
  import afo_pkg::*;
#(
  parameter int OW      = 12,
  parameter int DW      = 18,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic          clk,
  input  logic          mrst_sn,
  input  logic          prst_sn,
  input  logic          prog_sel,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off
);
  localparam int TOTAL = 2 * OW;
  localparam int SCW   = $clog2(TOTAL + 1);

  load_mode_e    mode_q, mode_d;
  logic [OW-1:0] ae_q, ae_d, af_q, af_d;
  logic          wtog_q, wtog_d;
  logic [SCW-1:0] scnt_q, scnt_d;
  logic          live, ser_hit, par_hit, ser_full;

  assign live     = mrst_sn && prst_sn;
  assign ser_full = (scnt_q == SCW'(TOTAL));
  assign ser_hit  = live && (mode_q == LOAD_SER) && ser_en && prog_sel && !ser_full;
  assign par_hit  = live && (mode_q == LOAD_PAR) && wr_en && prog_sel;

  always_comb begin
    mode_d = mode_q;
    ae_d   = ae_q;
    af_d   = af_q;
    wtog_d = wtog_q;
    scnt_d = scnt_q;
    if (ser_hit) begin
      for (int i = 0; i < OW; i++) begin
        if (scnt_q == SCW'(i))      ae_d[i] = ser_din;
        if (scnt_q == SCW'(i + OW)) af_d[i] = ser_din;
      end
      scnt_d = scnt_q + 1'b1;
    end
    if (par_hit) begin
      if (wtog_q) af_d = din[OW-1:0];
      else        ae_d = din[OW-1:0];
      wtog_d = ~wtog_q;
    end
    if (!mrst_sn) begin
      mode_d = prog_sel ? LOAD_PAR : LOAD_SER;
      ae_d   = prog_sel ? OW'(DEF_PAR) : OW'(DEF_SER);
      af_d   = prog_sel ? OW'(DEF_PAR) : OW'(DEF_SER);
    end
  end

  // configuration and offsets: loaded while master reset holds, no async clear
  always_ff @(posedge clk) begin
    mode_q <= mode_d;
    ae_q   <= ae_d;
    af_q   <= af_d;
  end

  always_ff @(posedge clk or negedge mrst_sn) begin
    if (!mrst_sn) begin
      wtog_q <= 1'b0;
      scnt_q <= '0;
    end else if (!prst_sn) begin
      wtog_q <= 1'b0;
      scnt_q <= '0;
    end else begin
      wtog_q <= wtog_d;
      scnt_q <= scnt_d;
    end
  end

  assign ae_off = ae_q;
  assign af_off = af_q;

  // R2
  par_toggle_chk: assert property (@(posedge clk) disable iff (!mrst_sn)
    (wr_en && prog_sel && prst_sn && mode_q == LOAD_PAR) |=> (wtog_q != $past(wtog_q)));

  // R4
  par_ignored_chk: assert property (@(posedge clk) disable iff (!mrst_sn)
    (mode_q == LOAD_SER && !(ser_en && prog_sel)) |=> ($stable(ae_q) && $stable(af_q)));

  // R3
  ser_done_chk: assert property (@(posedge clk) disable iff (!mrst_sn)
    (mode_q == LOAD_SER && scnt_q == SCW'(TOTAL)) |=> ($stable(ae_q) && $stable(af_q)));

  // R8
  prst_keep_chk: assert property (@(posedge clk) disable iff (!mrst_sn)
    (!prst_sn) |=> ($stable(ae_q) && $stable(af_q) && $stable(mode_q) && !wtog_q));
endmodule

// File: rtl/afo_readback.sv
module afo_readback #(
  parameter int OW = 12,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          mrst_sn,
  input  logic          prst_sn,
  input  logic          prog_sel,
  input  logic          rd_en,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output logic [DW-1:0] dout
);
  logic          rtog_q, rtog_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          rd_hit;

  assign rd_hit = prst_sn && rd_en && prog_sel;

  always_comb begin
    rtog_d = rtog_q;
    dout_d = dout_q;
    if (rd_hit) begin
      dout_d = DW'(rtog_q ? af_off : ae_off);
      rtog_d = ~rtog_q;
    end
  end

  always_ff @(posedge clk or negedge mrst_sn) begin
    if (!mrst_sn) begin
      rtog_q <= 1'b0;
      dout_q <= '0;
    end else if (!prst_sn) begin
      rtog_q <= 1'b0;
    end else begin
      rtog_q <= rtog_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  // R5
  rd_toggle_chk: assert property (@(posedge clk) disable iff (!mrst_sn)
    (rd_en && prog_sel && prst_sn) |=> (rtog_q != $past(rtog_q)));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!mrst_sn)
    !(rd_en && prog_sel) |=> $stable(dout_q));
endmodule

// File: rtl/afo_flags.sv
module afo_flags #(
  parameter int DEPTH = 4096,
  parameter int OW    = 12,
  parameter int CW    = 13
) (
  input  logic [CW-1:0] fill_cnt,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output logic          almost_empty,
  output logic          almost_full
);
  logic [CW-1:0] af_level;

  always_comb begin
    af_level     = CW'(DEPTH) - CW'(af_off);
    almost_empty = (fill_cnt <= CW'(ae_off));
    almost_full  = (fill_cnt >= af_level);
  end
endmodule

// File: rtl/afo_top.sv
module afo_top #(
  parameter int DEPTH   = 4096,
  parameter int DW      = 18,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023,
  localparam int OW     = $clog2(DEPTH),
  localparam int CW     = OW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          prog_sel,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          rd_en,
  output logic [DW-1:0] dout,
  input  logic [CW-1:0] fill_cnt,
  output logic          almost_empty,
  output logic          almost_full
);
  logic          w_mrst_sn, w_prst_sn, r_mrst_sn, r_prst_sn;
  logic [OW-1:0] ae_off, af_off;

  afo_rst_sync u_wm (.clk(wclk), .arst_n(mrst_n),            .rst_sn(w_mrst_sn));
  afo_rst_sync u_wp (.clk(wclk), .arst_n(mrst_n && prst_n),  .rst_sn(w_prst_sn));
  afo_rst_sync u_rm (.clk(rclk), .arst_n(mrst_n),            .rst_sn(r_mrst_sn));
  afo_rst_sync u_rp (.clk(rclk), .arst_n(mrst_n && prst_n),  .rst_sn(r_prst_sn));

  afo_wr_offsets #(.OW(OW), .DW(DW), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)) u_wr (
    .clk(wclk), .mrst_sn(w_mrst_sn), .prst_sn(w_prst_sn), .prog_sel(prog_sel),
    .ser_en(ser_en), .ser_din(ser_din), .wr_en(wr_en), .din(din),
    .ae_off(ae_off), .af_off(af_off)
  );

  afo_readback #(.OW(OW), .DW(DW)) u_rd (
    .clk(rclk), .mrst_sn(r_mrst_sn), .prst_sn(r_prst_sn), .prog_sel(prog_sel),
    .rd_en(rd_en), .ae_off(ae_off), .af_off(af_off), .dout(dout)
  );

  afo_flags #(.DEPTH(DEPTH), .OW(OW), .CW(CW)) u_fl (
    .fill_cnt(fill_cnt), .ae_off(ae_off), .af_off(af_off),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );
endmodule

// File: tb/tb_afo_top.sv
`timescale 1ns/1ps
module tb_afo_top;
  localparam int DEPTH = 4096;
  localparam int DW    = 18;
  localparam int OW    = 12;
  localparam int CW    = 13;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, prog_sel = 0, ser_en = 0, ser_din = 0, wr_en = 0, rd_en = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [CW-1:0] fill_cnt = '0;
  logic almost_empty, almost_full;

  int errors = 0, checks = 0;
  bit done = 0, mon_on = 0;
  int exp_q[$];
  string tag_q[$];
  int m_ae, m_af;
  bit m_rtog, m_wtog, m_par;

  always #2.5 wclk = ~wclk;
  initial begin #1; forever #2.5 rclk = ~rclk; end

  afo_top dut (.wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .prog_sel(prog_sel),
    .ser_en(ser_en), .ser_din(ser_din), .wr_en(wr_en), .din(din), .rd_en(rd_en), .dout(dout),
    .fill_cnt(fill_cnt), .almost_empty(almost_empty), .almost_full(almost_full));

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: pops expected readback words as dout updates
  initial forever begin
    @(posedge rclk);
    if (mon_on && rd_en && prog_sel) begin
      #2;
      if (exp_q.size() == 0) check("R5 unexpected read", 1, 0);
      else check(tag_q.pop_front(), int'(dout), exp_q.pop_front());
    end
  end

  task automatic rd_exp(string tag);
    exp_q.push_back(m_rtog ? m_af : m_ae);
    tag_q.push_back(tag);
    m_rtog = ~m_rtog;
    @(negedge rclk); rd_en = 1; prog_sel = 1;
    @(negedge rclk); rd_en = 0; prog_sel = 0;
    @(negedge rclk);
  endtask

  task automatic do_mrst(bit sel);
    mon_on = 0;
    @(negedge wclk); mrst_n = 0; prog_sel = sel;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    repeat (2) @(negedge wclk);
    prog_sel = 0;
    repeat (4) @(negedge wclk);
    m_par = sel; m_ae = sel ? 127 : 1023; m_af = m_ae; m_rtog = 0; m_wtog = 0;
    mon_on = 1;
  endtask

  task automatic do_prst();
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1;
    repeat (5) @(negedge wclk);
    m_rtog = 0; m_wtog = 0;
  endtask

  task automatic par_write(int v);
    @(negedge wclk); wr_en = 1; prog_sel = 1; din = DW'(v);
    @(negedge wclk); wr_en = 0; prog_sel = 0;
    if (m_par) begin
      if (m_wtog) m_af = v; else m_ae = v;
      m_wtog = ~m_wtog;
    end
  endtask

  task automatic ser_bit(bit b);
    @(negedge wclk); ser_en = 1; prog_sel = 1; ser_din = b;
    @(negedge wclk); ser_en = 0; prog_sel = 0;
  endtask

  task automatic flag(int cnt, bit eae, bit eaf, string tag);
    fill_cnt = CW'(cnt); #1;
    check({"R6 almost_empty ", tag}, int'(almost_empty), int'(eae));
    check({"R7 almost_full ", tag}, int'(almost_full), int'(eaf));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: parallel mode, default 127
    do_mrst(1'b1);
    check("R1 dout after reset", int'(dout), 0);
    rd_exp("R1 default ae parallel");
    rd_exp("R1 default af parallel");
    flag(127, 1, 0, "R6 default edge");
    flag(128, 0, 0, "R6 default above");
    flag(DEPTH - 127, 0, 1, "R7 default edge");
    flag(DEPTH - 128, 0, 0, "R7 default below");
    // R2: parallel load alternates
    par_write(50);
    par_write(3000);
    rd_exp("R2 ae loaded"); rd_exp("R2 af loaded"); rd_exp("R5 wrap to ae");
    flag(50, 1, 0, "R6 at 50"); flag(51, 0, 0, "R6 at 51");
    flag(1095, 0, 0, "R7 at 1095"); flag(1096, 0, 1, "R7 at 1096");
    flag(DEPTH, 0, 1, "R7 full"); flag(0, 1, 0, "R6 empty");
    // R4: serial strobes ignored in parallel mode
    for (int i = 0; i < 5; i++) ser_bit(1'b1);
    m_rtog = 0; // next read continues after the wrap: ae read above flipped to af
    m_rtog = 1;
    rd_exp("R4 af unchanged by serial"); rd_exp("R4 ae unchanged by serial");
    // R8: partial reset keeps offsets, resets toggles
    par_write(77);
    do_prst();
    par_write(88);
    rd_exp("R8 ae after partial reset"); rd_exp("R8 af kept");
    flag(88, 1, 0, "R8 ae threshold"); flag(89, 0, 0, "R8 ae threshold+1");
    // R1: serial mode, default 1023
    do_mrst(1'b0);
    check("R1 dout after second reset", int'(dout), 0);
    rd_exp("R1 default ae serial"); rd_exp("R1 default af serial");
    // R4: parallel write ignored in serial mode
    par_write(5);
    rd_exp("R4 ae unchanged by parallel"); rd_exp("R4 af unchanged by parallel");
    // R3: serial load LSB first, ae then af, then stop
    for (int i = 0; i < OW; i++) ser_bit(1'((300 >> i) & 1));
    for (int i = 0; i < OW; i++) ser_bit(1'((2000 >> i) & 1));
    for (int i = 0; i < 4; i++) ser_bit(1'b1);
    m_ae = 300; m_af = 2000;
    rd_exp("R3 serial ae"); rd_exp("R3 serial af");
    flag(300, 1, 0, "R3 ae edge"); flag(301, 0, 0, "R3 ae edge+1");
    flag(2095, 0, 0, "R3 af edge-1"); flag(2096, 0, 1, "R3 af edge");
    // R8: partial reset restarts the serial sequence at ae bit 0
    do_prst();
    for (int i = 0; i < OW; i++) ser_bit(1'((9 >> i) & 1));
    m_ae = 9;
    rd_exp("R8 serial restart ae"); rd_exp("R8 serial af kept");
    repeat (4) @(negedge rclk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule